// File: doc/BRIEF.md
# Buffered Factory Programming Sequencer

This block drives high-throughput bulk programming of a single flash block. A host issues a two-write entry sequence: a setup code, then a confirm code. The address of the setup write becomes the first-word address. After that, the host streams data words to that same address with no further commands and no word counts. The sequencer collects the words in a 32-word write buffer. When the buffer is full, it drains the buffer into the array and waits out a fixed program/verify latency. It then moves its internal array pointer to the next 32-word boundary, ready for the next buffer.

The host polls a status byte to learn when the next buffer may be loaded. The status byte also reports the entry errors: a missing confirm, low programming voltage, a locked block, a misaligned start address, and running past the end of the block. The host leaves the sequence by writing to any other address while the buffer is empty. The analog program and verify pulses are not modelled; a fixed cycle count stands in for them.

Top module: `bfp_seq`

## Requirements
- R1: The `phase` output encodes idle=0, setup=1, program/verify=2, exit=3. From idle, phase only moves to setup. The exit phase lasts exactly one cycle and is followed by idle.
- R2: In idle, a write whose low data byte is 0x80 enters setup and latches the write address as the first-word address. In setup, a write of 0xD0 with all preconditions met enters program/verify. Any other data written in setup sets status bits 5 and 4 and goes to exit.
- R3: Array programming begins only after the 32nd data write to the first-word address. Status bit 0 is 0 after 31 such writes, and is 1 in the cycle after the 32nd.
- R4: Each buffer is written to the array on `arr_*` over 32 consecutive cycles. The addresses run upward from the current base, and the data comes out in load order. The base starts at the first-word address and rises by 32 after each buffer, with no new command.
- R5: Status bit 0 stays 1 for exactly 32 + PGM_LAT cycles per buffer, then returns to 0 with phase still at program/verify.
- R6: In program/verify, with the buffer empty and not busy, a write to an address other than the first-word address goes to exit and then idle. With a partly filled buffer, such a write is ignored: it neither stores data nor changes phase.
- R7: A confirm with a first-word address whose low 5 bits are not zero sets status bit 4 and exits, with no array write. A data write after the last buffer of the block has been programmed sets status bit 4 and exits.
- R8: Low programming voltage (`vpp_ok`=0) at confirm, or at the 32nd buffer write, sets status bits 4 and 3 and exits, with no array write. Status bits 5, 4, 3 and 1 hold until a 0x50 write in idle clears them.
- R9: While status bit 0 is 1, all host writes, including a suspend code 0xB0, are ignored. Programming runs to completion, and the next buffer starts empty.
- R10: A confirm while `blk_unlocked`=0 sets status bits 4 and 1 and exits, with no array write.
- R11: After reset, phase is 0, status is 0x80 (bit 7 = ready, which is 1 in idle), and `arr_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we | input | 1 | Host write strobe, one cycle per write |
| addr | input | ADDR_W | Host write address |
| wdata | input | DATA_W | Host write data or command code (low byte) |
| blk_unlocked | input | 1 | Target block is unlocked |
| vpp_ok | input | 1 | Programming voltage is above lockout |
| status | output | 8 | Status byte: 7 ready, 5 command error, 4 program error, 3 voltage error, 1 lock error, 0 buffer busy |
| phase | output | 2 | Current phase code |
| arr_we | output | 1 | Array word write strobe |
| arr_addr | output | ADDR_W | Array word address |
| arr_wdata | output | DATA_W | Array word data |

## Verification
The block-end error can only be reached after four complete buffers of 32 writes each have been streamed and programmed. The bench therefore fills a whole 128-word block through the normal polling flow before it attempts one more data write. Writes that arrive during a busy buffer are also hard to place: the bench injects a suspend code and a stray-address write right after the 32nd load. It then fills a further full buffer to show that no stray word leaked into the buffer.

// File: rtl/bfp_seq.sv
module bfp_seq #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int BUF_WORDS   = 32,
  parameter int BLOCK_WORDS = 128,
  parameter int PGM_LAT     = 6,
  parameter logic [7:0] CMD_SETUP   = 8'h80,
  parameter logic [7:0] CMD_CONFIRM = 8'hD0,
  parameter logic [7:0] CMD_CLEAR   = 8'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              blk_unlocked,
  input  logic              vpp_ok,
  output logic [7:0]        status,
  output logic [1:0]        phase,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int BUF_W     = $clog2(BUF_WORDS);
  localparam int BLK_W     = $clog2(BLOCK_WORDS);
  localparam int CNT_W     = $clog2(BUF_WORDS + PGM_LAT + 1);
  localparam int PROG_LAST = BUF_WORDS + PGM_LAT - 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_FILL, S_PROG, S_EXIT} st_t;

  st_t               st;
  logic [ADDR_W-1:0] wa0, base;
  logic [CNT_W-1:0]  cnt;
  logic              at_end, e_cmd, e_prog, e_vpp, e_lock;
  logic [DATA_W-1:0] wbuf [BUF_WORDS];
  logic [7:0]        cmd;
  logic              load;

  assign cmd  = wdata[7:0];
  assign load = (st == S_FILL) && we && (addr == wa0) && !at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; wa0 <= '0; base <= '0; cnt <= '0; at_end <= 1'b0;
      e_cmd <= 1'b0; e_prog <= 1'b0; e_vpp <= 1'b0; e_lock <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (we) begin
          if (cmd == CMD_SETUP) begin
            wa0 <= addr;
            st  <= S_SETUP;
          end else if (cmd == CMD_CLEAR) begin
            e_cmd <= 1'b0; e_prog <= 1'b0; e_vpp <= 1'b0; e_lock <= 1'b0;
          end
        end
        S_SETUP: if (we) begin
          st <= S_EXIT;
          if (cmd != CMD_CONFIRM) begin
            e_cmd <= 1'b1; e_prog <= 1'b1;
          end else if (!vpp_ok) begin
            e_vpp <= 1'b1; e_prog <= 1'b1;
          end else if (!blk_unlocked) begin
            e_lock <= 1'b1; e_prog <= 1'b1;
          end else if (wa0[BUF_W-1:0] != '0) begin
            e_prog <= 1'b1;
          end else begin
            st <= S_FILL; base <= wa0; cnt <= '0; at_end <= 1'b0;
          end
        end
        S_FILL: if (we) begin
          if (addr == wa0) begin
            if (at_end) begin
              e_prog <= 1'b1;
              st     <= S_EXIT;
            end else if (cnt == CNT_W'(BUF_WORDS - 1)) begin
              cnt <= '0;
              if (!vpp_ok) begin
                e_vpp <= 1'b1; e_prog <= 1'b1; st <= S_EXIT;
              end else begin
                st <= S_PROG;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (cnt == '0) begin
            st <= S_EXIT;
          end
        end
        S_PROG: begin
          if (cnt == CNT_W'(PROG_LAST)) begin
            cnt    <= '0;
            st     <= S_FILL;
            base   <= base + ADDR_W'(BUF_WORDS);
            at_end <= &base[BLK_W-1:BUF_W];
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st  <= S_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk)
    if (load) wbuf[cnt[BUF_W-1:0]] <= wdata;

  assign arr_we    = (st == S_PROG) && (cnt < CNT_W'(BUF_WORDS));
  assign arr_addr  = {base[ADDR_W-1:BUF_W], cnt[BUF_W-1:0]};
  assign arr_wdata = wbuf[cnt[BUF_W-1:0]];
  assign status    = {st == S_IDLE, 1'b0, e_cmd, e_prog, e_vpp, 1'b0, e_lock, st == S_PROG};

  always_comb begin
    case (st)
      S_IDLE:         phase = 2'd0;
      S_SETUP:        phase = 2'd1;
      S_FILL, S_PROG: phase = 2'd2;
      default:        phase = 2'd3;
    endcase
  end
endmodule

// File: rtl/bfp_seq_chk.sv
module bfp_seq_chk #(
  parameter int ADDR_W = 12,
  parameter int BUF_W  = 5,
  parameter logic [7:0] CMD_CLEAR = 8'h50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we,
  input logic [7:0]        cmd,
  input logic [7:0]        status,
  input logic [1:0]        phase,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  assert_exit_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd3 |=> phase == 2'd0);

  assert_idle_only_to_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd0 |=> phase <= 2'd1);

  assert_prog_starts_draining_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> arr_we);

  assert_addr_sequential_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we && $past(arr_we) |-> arr_addr == ADDR_W'($past(arr_addr) + 1'b1));

  assert_buffer_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we && !$past(arr_we) |-> arr_addr[BUF_W-1:0] == '0);

  assert_vpp_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] && !(we && cmd == CMD_CLEAR && phase == 2'd0) |=> status[3]);

  assert_prog_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] && !(we && cmd == CMD_CLEAR && phase == 2'd0) |=> status[4]);

  assert_no_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |=> phase == 2'd2);
endmodule

bind bfp_seq bfp_seq_chk #(.ADDR_W(ADDR_W), .BUF_W(BUF_W), .CMD_CLEAR(CMD_CLEAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .cmd(wdata[7:0]), .status(status),
  .phase(phase), .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/tb_bfp_seq.sv
module tb_bfp_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12, DW = 16, NBUF = 32, LAT = 6;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, blk_unlocked = 1'b1, vpp_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [7:0] status;
  logic [1:0] phase;
  logic arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;

  int nchk = 0, nfail = 0, nw = 0;
  logic [AW-1:0] cap_a [64];
  logic [DW-1:0] cap_d [64];

  bfp_seq #(.ADDR_W(AW), .DATA_W(DW), .BUF_WORDS(NBUF), .BLOCK_WORDS(128), .PGM_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .blk_unlocked(blk_unlocked), .vpp_ok(vpp_ok), .status(status), .phase(phase),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && arr_we) begin
    if (nw < 64) begin cap_a[nw] = arr_addr; cap_d[nw] = arr_wdata; end
    nw = nw + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic exp_exit(input string tag, input logic [7:0] st);
    chk({tag, " exit phase"}, phase, 3);
    @(negedge clk);
    chk({tag, " idle after exit"}, phase, 0);
    chk({tag, " status"}, status, st);
  endtask

  task automatic enter(input logic [AW-1:0] wa);
    wr(wa, 16'h0080);
    chk("R2 setup phase", phase, 1);
    wr(wa, 16'h00D0);
    chk("R1 R2 program/verify phase", phase, 2);
  endtask

  task automatic wait_idle_buf(output int n);
    n = 0;
    while (status[0] && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic check_drain(input string tag, input logic [AW-1:0] b, input logic [DW-1:0] seed);
    chk({tag, " R4 word count"}, nw, NBUF);
    for (int i = 0; i < NBUF; i++) begin
      chk({tag, " R4 addr"}, cap_a[i], 32'(b + AW'(i)));
      chk({tag, " R4 data"}, cap_d[i], 32'(seed + DW'(i)));
    end
  endtask

  task automatic fill_buf(input logic [AW-1:0] wa, input logic [DW-1:0] seed, input logic [AW-1:0] b);
    int n;
    nw = 0;
    for (int i = 0; i < NBUF - 1; i++) wr(wa, seed + DW'(i));
    chk("R3 not busy after 31 words", status[0], 0);
    wr(wa, seed + DW'(NBUF - 1));
    chk("R3 busy after 32nd word", status[0], 1);
    wait_idle_buf(n);
    chk("R5 busy cycles", n, NBUF + LAT);
    chk("R5 phase after buffer", phase, 2);
    check_drain("fill", b, seed);
  endtask

  task automatic t_reset;
    chk("R11 reset phase", phase, 0);
    chk("R11 reset status", status, 8'h80);
    chk("R11 reset arr_we", arr_we, 0);
  endtask

  task automatic t_full_block;
    enter(12'h100);
    for (int k = 0; k < 4; k++) fill_buf(12'h100, DW'(16'h1000 * (k + 1)), AW'(12'h100 + 32 * k));
    nw = 0;
    wr(12'h100, 16'hBEEF);
    exp_exit("R7 block end", 8'h90);
    chk("R7 no write past block", nw, 0);
    wr(12'h000, 16'h0050);
    chk("R8 clear status", status, 8'h80);
  endtask

  task automatic t_ignored_writes;
    int n;
    enter(12'h200);
    nw = 0;
    for (int i = 0; i < 5; i++) wr(12'h200, 16'h5A00 + DW'(i));
    wr(12'h233, 16'hDEAD);
    chk("R6 stray write ignored phase", phase, 2);
    for (int i = 5; i < NBUF; i++) wr(12'h200, 16'h5A00 + DW'(i));
    chk("R3 busy", status[0], 1);
    wr(12'h200, 16'h00B0);
    wr(12'h244, 16'h00B0);
    chk("R9 suspend ignored busy", status[0], 1);
    chk("R9 suspend ignored phase", phase, 2);
    wait_idle_buf(n);
    chk("R9 programming completes", status[0], 0);
    check_drain("R6 R9", 12'h200, 16'h5A00);
    fill_buf(12'h200, 16'h7700, 12'h220);
    wr(12'h201, 16'h0000);
    exp_exit("R6 exit on other address", 8'h80);
  endtask

  task automatic t_misaligned;
    nw = 0;
    wr(12'h105, 16'h0080);
    wr(12'h105, 16'h00D0);
    exp_exit("R7 misaligned", 8'h90);
    chk("R7 no array write", nw, 0);
    wr(12'h000, 16'h0050);
  endtask

  task automatic t_vpp;
    nw = 0;
    vpp_ok = 1'b0;
    wr(12'h100, 16'h0080);
    wr(12'h100, 16'h00D0);
    exp_exit("R8 vpp at confirm", 8'h98);
    vpp_ok = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 sticky", status, 8'h98);
    wr(12'h000, 16'h0050);
    chk("R8 cleared", status, 8'h80);
    enter(12'h100);
    for (int i = 0; i < NBUF - 1; i++) wr(12'h100, DW'(i));
    vpp_ok = 1'b0;
    wr(12'h100, 16'h0031);
    exp_exit("R8 vpp at buffer full", 8'h98);
    chk("R8 no array write", nw, 0);
    vpp_ok = 1'b1;
    wr(12'h000, 16'h0050);
  endtask

  task automatic t_locked;
    blk_unlocked = 1'b0;
    wr(12'h100, 16'h0080);
    wr(12'h100, 16'h00D0);
    exp_exit("R10 locked", 8'h92);
    blk_unlocked = 1'b1;
    wr(12'h000, 16'h0050);
    chk("R10 cleared", status, 8'h80);
  endtask

  task automatic t_bad_confirm;
    wr(12'h100, 16'h0080);
    wr(12'h100, 16'h00FF);
    exp_exit("R2 bad confirm", 8'hB0);
    wr(12'h000, 16'h0050);
    chk("R2 cleared", status, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_full_block;
    t_ignored_writes;
    t_misaligned;
    t_vpp;
    t_locked;
    t_bad_confirm;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule